// File: doc/BRIEF.md
# Frequency-Compensated Beep Tone Generator

This block makes a square-wave beep tone from one bit of a free-running counter. The counter advances once every two system clocks. Software picks the counter bit through a nine-bit tap field in a count register and switches the tone on or off through a single enable bit in a control register.

A power-management sequencer can slow the system clock to one half or to one thirty-second of its full rate. It reports the current rate on a two-bit frequency code. The block then moves to a lower counter bit by itself, so the pitch heard stays the same. The tone output is registered and is meant to feed a speaker driver outside this block.

Top module: `beep_tone_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, tone_out is 0 and both registers read back as all zeros.
- R2: Register address 0 is the control register. A write stores wdata bit 0 as the enable. Read data bits 31..1 at that address are always 0, whatever was written to them.
- R3: Register address 1 is the count register. A write stores wdata bits 18..10 as the tap field, and reading gives that field back in the same bits. All other read bits are 0, whatever was written to them.
- R4: The internal counter starts at 0 after reset and goes up by one on every second clock edge. With the frequency code at 0, the enable set and field bit 0 as the only bit set, tone_out is a square wave with a period of 4096 clocks, 2048 high and 2048 low. tone_out is registered: after clock edge e (counting from the first edge after reset), it equals bit 10 of the counter value held before that edge, which is floor((e-1)/2).
- R5: If the field has more than one bit set, the lowest set bit k is used. Tap k drives tone_out from counter bit 10+k.
- R6: An all-zero tap field holds tone_out at 0.
- R7: A frequency code of 1 (half rate) lowers the tap used by 1. A code of 2 (1/32 rate) lowers it by 5. The result is clamped at tap 0. Codes 0 and 3 leave the tap unchanged. A change of code takes effect at the next clock edge.
- R8: With the enable bit clear, tone_out is 0 at every edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register picked by reg_addr |
| freq_code | input | 2 | Current system clock rate code |
| tone_out | output | 1 | Beep tone |

## Verification
Two things can land on the same clock edge: a register write that changes the enable or the tap field, and a change of the frequency code that moves the effective tap. The random stimulus lets both happen on one edge, and does so often, including near edges where the counter bit is about to toggle. A directed section also forces a field write and a code change onto the same edge. Every cycle, the bench works out the expected tone from the configuration that was in force before that edge and the code present at it, and it applies the write only afterwards. Any design that lets the new configuration leak into the same edge, or that samples the code one cycle late, therefore shows up as a mismatch.

// File: rtl/beep_pkg.sv
package beep_pkg;
    // Frequency codes from the power-management sequencer
    typedef enum logic [1:0] {
        FREQ_FULL = 2'd0,
        FREQ_HALF = 2'd1,
        FREQ_SLOW = 2'd2,
        FREQ_RSVD = 2'd3
    } freq_e;

    localparam logic ADDR_CTRL  = 1'b0;
    localparam logic ADDR_COUNT = 1'b1;
endpackage

// File: rtl/beep_regs.sv
module beep_regs #(
    parameter int DATA_W   = 32,
    parameter int TAP_BASE = 10,
    parameter int TAP_NUM  = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               en,
    output logic [TAP_NUM-1:0] field
);
    import beep_pkg::*;

    typedef struct packed {
        logic               en;
        logic [TAP_NUM-1:0] fld;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (addr == ADDR_CTRL) st_d.en  = wdata[0];
            else                   st_d.fld = wdata[TAP_BASE +: TAP_NUM];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL) rdata[0] = st_q.en;
        else                   rdata[TAP_BASE +: TAP_NUM] = st_q.fld;
    end

    assign en    = st_q.en;
    assign field = st_q.fld;

    // R2
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_CTRL) |=> (en == $past(wdata[0])));

    // R3
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr && addr == ADDR_COUNT)) |=> $stable(field));
endmodule

// File: rtl/beep_counter.sv
module beep_counter #(
    parameter int CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic             phase;
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (st_q.phase) st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R4
    half_rate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase |=> (cnt == $past(cnt) + CNT_W'(1)));

    // R4
    half_rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.phase |=> $stable(cnt));
endmodule

// File: rtl/beep_tap_sel.sv
module beep_tap_sel #(
    parameter int TAP_NUM    = 9,
    parameter int HALF_SHIFT = 1,
    parameter int SLOW_SHIFT = 5,
    parameter int IDX_W      = $clog2(TAP_NUM)
) (
    input  logic [TAP_NUM-1:0] field,
    input  logic [1:0]         freq,
    output logic               valid,
    output logic [IDX_W-1:0]   idx
);
    import beep_pkg::*;

    int req_i;
    int sh_i;
    int eff_i;

    always_comb begin
        req_i = 0;
        for (int k = TAP_NUM - 1; k >= 0; k--) begin
            if (field[k]) req_i = k;
        end
        valid = |field;
        case (freq)
            FREQ_HALF: sh_i = HALF_SHIFT;
            FREQ_SLOW: sh_i = SLOW_SHIFT;
            default:   sh_i = 0;
        endcase
        eff_i = (req_i > sh_i) ? (req_i - sh_i) : 0;
        idx   = IDX_W'(eff_i);
    end

    // R7
    always_comb begin
        clamp_chk: assert (int'(idx) <= req_i && int'(idx) < TAP_NUM);
    end
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen #(
    parameter int DATA_W     = 32,
    parameter int TAP_BASE   = 10,
    parameter int TAP_NUM    = 9,
    parameter int HALF_SHIFT = 1,
    parameter int SLOW_SHIFT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [1:0]        freq_code,
    output logic              tone_out
);
    localparam int CNT_W = TAP_BASE + TAP_NUM;
    localparam int IDX_W = $clog2(TAP_NUM);

    typedef struct packed {
        logic tone;
    } out_t;

    logic               en;
    logic [TAP_NUM-1:0] field;
    logic [CNT_W-1:0]   cnt;
    logic               sel_valid;
    logic [IDX_W-1:0]   sel_idx;
    logic [CNT_W-1:0]   cnt_sh;
    out_t               st_d, st_q;

    beep_regs #(.DATA_W(DATA_W), .TAP_BASE(TAP_BASE), .TAP_NUM(TAP_NUM)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .en(en), .field(field)
    );

    beep_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt(cnt)
    );

    beep_tap_sel #(.TAP_NUM(TAP_NUM), .HALF_SHIFT(HALF_SHIFT),
                   .SLOW_SHIFT(SLOW_SHIFT), .IDX_W(IDX_W)) u_sel (
        .field(field), .freq(freq_code), .valid(sel_valid), .idx(sel_idx)
    );

    always_comb begin
        cnt_sh    = cnt >> (TAP_BASE + int'(sel_idx));
        st_d.tone = en & sel_valid & cnt_sh[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tone_out = st_q.tone;

    // R8
    mute_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tone_out);

    // R6
    empty_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field == '0) |=> !tone_out);
endmodule

// File: tb/sim_beep_tone_gen.sv
module sim_beep_tone_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  freq_code = 2'd0;
    logic        tone_out;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 0;

    longint   edge_n = 0;
    bit       m_en = 0;
    bit [8:0] m_fld = '0;

    always #4 clk = ~clk;

    beep_tone_gen u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .freq_code(freq_code), .tone_out(tone_out)
    );

    function automatic bit exp_tone(longint e, bit en, bit [8:0] fld, bit [1:0] fq);
        int     k;
        int     sh;
        longint c;
        if (!en || fld == 0) return 1'b0;
        k = 0;
        for (int i = 8; i >= 0; i--) if (fld[i]) k = i;
        sh = (fq == 2'd1) ? 1 : (fq == 2'd2) ? 5 : 0;
        k  = (k > sh) ? k - sh : 0;
        c  = (e - 1) / 2;
        return bit'((c >> (10 + k)) & 1);
    endfunction

    function automatic string tone_tag(bit en, bit [8:0] fld, bit [1:0] fq);
        if (!en)      return "R8";
        if (fld == 0) return "R6";
        if (fq == 2'd1 || fq == 2'd2) return "R7";
        if ($countones(fld) > 1) return "R5";
        return "R4";
    endfunction

    function automatic bit [31:0] exp_rd(bit a);
        if (!a) return {31'b0, m_en};
        return {13'b0, m_fld, 10'b0};
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, edge_n);
        end
    endtask

    // one clock: drive at negedge, predict, advance, compare at next negedge
    task automatic step(bit wr, bit a, bit [31:0] d, bit [1:0] fq);
        bit    e_t;
        string tg;
        reg_wr = wr; reg_addr = a; reg_wdata = d; freq_code = fq;
        e_t = exp_tone(edge_n + 1, m_en, m_fld, fq);
        tg  = tone_tag(m_en, m_fld, fq);
        if (wr) begin
            if (!a) m_en = d[0];
            else    m_fld = d[18:10];
        end
        edge_n++;
        @(negedge clk);
        check(tg, tone_out, e_t);
        check(a ? "R3" : "R2", reg_rdata, exp_rd(a));
    endtask

    task automatic idle(int n, bit [1:0] fq);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 32'd0, fq);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", tone_out, 0);
        reg_addr = 1'b0; #1 check("R1", reg_rdata, 0);
        reg_addr = 1'b1; #1 check("R1", reg_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b1, 32'd0, 2'd0);
        check("R1", tone_out, 0);

        // R2/R3: reserved bits written high read back zero
        step(1'b1, 1'b0, 32'hFFFF_FFFE, 2'd0);
        step(1'b1, 1'b1, 32'hFFF8_03FF, 2'd0);
        check("R3", reg_rdata, 0);
        // R4: enable with base tap, several periods at full rate
        step(1'b1, 1'b1, 32'h0000_0400, 2'd0);
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 2'd0);
        idle(9000, 2'd0);
        // R5: several bits set, lowest (tap 1) used
        step(1'b1, 1'b1, 32'h0006_1800, 2'd0);
        idle(9000, 2'd0);
        // R7: half rate moves tap 1 down to tap 0
        idle(6000, 2'd1);
        // R7: field write and code change on the same edge; tap 2 clamps to 0
        step(1'b1, 1'b1, 32'h0000_1000, 2'd2);
        idle(6000, 2'd2);
        idle(3000, 2'd3);
        // R6: empty field
        step(1'b1, 1'b1, 32'h0000_0000, 2'd0);
        idle(3000, 2'd0);
        // R8: disabled
        step(1'b1, 1'b1, 32'h0000_0400, 2'd0);
        step(1'b1, 1'b0, 32'h0000_0000, 2'd0);
        idle(3000, 2'd0);

        // constrained random
        for (int i = 0; i < 120000; i++) begin
            bit        wr;
            bit        a;
            bit [31:0] d;
            bit [1:0]  fq;
            wr = ($urandom % 16) == 0;
            a  = bit'($urandom % 2);
            d  = $urandom;
            if (a && ($urandom % 4) != 0) d[18:10] = 9'(1 << ($urandom % 4)) | 9'($urandom % 2 ? 9'h100 : 9'h0);
            if (!a && ($urandom % 8) != 0) d[0] = 1'b1;
            fq = ($urandom % 64 == 0) ? 2'($urandom % 4) : freq_code;
            step(wr, a, d, fq);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule